// File: doc/BRIEF.md
# Global-History Branch Direction Predictor with Checkpoint Repair

This block predicts whether a conditional branch will be taken. It keeps one global history register of recent branch directions and a table of 2-bit saturating counters. The table is indexed by the XOR of a slice of the branch address with that history. The counter's upper bit is the prediction. When a prediction is accepted, the predicted direction is shifted into the history at once, so that younger branches see the speculative path. On the same cycle the history value from before that shift is saved in a checkpoint queue.

Branches commit in program order through the commit stream. A commit that was predicted correctly drops the oldest checkpoint. A commit that was mispredicted rebuilds the history: the real outcome is shifted into the oldest checkpoint, and every younger checkpoint is discarded. Each commit also trains one counter using the real outcome. That counter's index is recomputed from the committed address and the oldest checkpoint, which is the history the prediction used.

Both streams use valid/ready. The predict stream is accepted when `pred_valid` and `pred_ready` are both high on a rising edge. `pred_ready` is low while the checkpoint queue is full and during a cycle in which a mispredicted commit is accepted. `pred_taken` is combinational from `pred_pc` and the current history, and it is meaningful while `pred_valid` is high. The commit stream is accepted when `cm_valid` and `cm_ready` are both high, and `cm_ready` is high whenever at least one checkpoint is held. Inputs may be held or withdrawn freely while their ready is low.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is zero, the checkpoint queue is empty (`cm_ready` low, `pred_ready` high), and every counter is weak not-taken, so every address predicts not-taken.
- R2: `pred_taken` equals bit 1 of the counter at index `pred_pc[9:2] XOR ghist`.
- R3: Counters are encoded 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken commit moves a counter up by one and stops at 11. A not-taken commit moves it down by one and stops at 00.
- R4: A counter in a strong state needs two consecutive opposite commits before its predicted direction changes.
- R5: On an accepted prediction, `ghist` becomes `{ghist[6:0], pred_taken}` on the next edge.
- R6: An accepted prediction pushes the pre-update history as a checkpoint. `cm_ready` is high while at least one checkpoint is held.
- R7: A commit with `cm_mispredict` low discards the oldest checkpoint and leaves `ghist` unchanged. With no accepted prediction and no recovery, `ghist` holds.
- R8: A commit with `cm_mispredict` high sets `ghist` to `{oldest_checkpoint[6:0], cm_taken}` and empties the checkpoint queue.
- R9: Every accepted commit trains the counter at index `cm_pc[9:2] XOR oldest_checkpoint` with `cm_taken`.
- R10: When eight checkpoints are held, `pred_ready` is low, and a presented prediction changes neither the history nor the queue.
- R11: In a cycle in which a mispredicted commit is accepted, `pred_ready` is low, so the recovery wins over a new prediction.
- R12: A commit presented while the queue is empty is not accepted. It changes no counter and leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Prediction request valid |
| pred_ready | output | 1 | Prediction request can be accepted |
| pred_pc | input | 32 | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| cm_valid | input | 1 | Commit valid |
| cm_ready | output | 1 | Commit can be accepted (checkpoint present) |
| cm_pc | input | 32 | Address of the committing branch |
| cm_taken | input | 1 | Resolved direction, 1 = taken |
| cm_mispredict | input | 1 | Committing branch was mispredicted |
| ghist | output | 8 | Current global history |

## Verification
Two situations are hard to reach from the ports. The first is a full queue meeting a commit in the same cycle. The second is a mispredicted commit colliding with a new prediction, where the recovery must win. The stimulus drives the predict stream much more often than the commit stream, so the queue fills regularly. Directed sequences then push exactly eight predictions, present a ninth, and raise a mispredicted commit alongside a pending prediction. To drive a single counter through both saturation ends, each address is chosen as the target index XOR the history the bench expects at that moment. This cancels the moving speculative history.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // saturating step toward the resolved direction
  function automatic ctr_e ctr_next(ctr_e cur, logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_dir(ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_en,
  input  logic              spec_bit,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_base,
  input  logic              fix_bit,
  output logic [HIST_W-1:0] hist
);

  // repair has priority over a speculative shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (fix_en) begin
      hist <= {fix_base[HIST_W-2:0], fix_bit};
    end else if (spec_en) begin
      hist <= {hist[HIST_W-2:0], spec_bit};
    end
  end

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr_e ctr_mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ctr_mem[i] <= CTR_WNT;
      end
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= ctr_next(ctr_mem[wr_idx], wr_taken);
    end
  end

  // read returns the value before any same-cycle training
  assign rd_ctr = ctr_mem[rd_idx];

endmodule

// File: rtl/gshare_ckpt_fifo.sv
module gshare_ckpt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      slot[wr_ptr] <= push_data;
    end
  end

  assign head  = slot[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int HIST_W     = 8,
  parameter int PC_LSB     = 2,
  parameter int CKPT_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  input  logic              cm_valid,
  output logic              cm_ready,
  input  logic [PC_W-1:0]   cm_pc,
  input  logic              cm_taken,
  input  logic              cm_mispredict,
  output logic [HIST_W-1:0] ghist
);

  logic              ck_full, ck_empty;
  logic [HIST_W-1:0] ck_head;
  logic              cm_fire, recover, pred_fire;
  logic [HIST_W-1:0] rd_idx, wr_idx;
  ctr_e              rd_ctr;
  logic              pc_bits_unused;

  assign cm_ready   = !ck_empty;
  assign cm_fire    = cm_valid && cm_ready;
  assign recover    = cm_fire && cm_mispredict;
  assign pred_ready = !ck_full && !recover;
  assign pred_fire  = pred_valid && pred_ready;

  assign rd_idx     = pred_pc[PC_LSB +: HIST_W] ^ ghist;
  assign wr_idx     = cm_pc[PC_LSB +: HIST_W] ^ ck_head;
  assign pred_taken = ctr_dir(rd_ctr);

  assign pc_bits_unused = ^{pred_pc, cm_pc};

  gshare_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .spec_en  (pred_fire),
    .spec_bit (pred_taken),
    .fix_en   (recover),
    .fix_base (ck_head),
    .fix_bit  (cm_taken),
    .hist     (ghist)
  );

  gshare_pht #(.IDX_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (cm_fire),
    .wr_idx   (wr_idx),
    .wr_taken (cm_taken)
  );

  gshare_ckpt_fifo #(.W(HIST_W), .DEPTH(CKPT_DEPTH)) u_ckpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pred_fire),
    .push_data (ghist),
    .pop       (cm_fire && !cm_mispredict),
    .flush     (recover),
    .head      (ck_head),
    .full      (ck_full),
    .empty     (ck_empty)
  );

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int HIST_W     = 8,
  parameter int CKPT_DEPTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic              pred_taken,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic              cm_mispredict,
  input logic [HIST_W-1:0] ghist
);

  localparam int OCC_W = $clog2(CKPT_DEPTH + 1);

  logic             pf, cf, rec;
  logic [OCC_W-1:0] occ;

  assign pf  = pred_valid && pred_ready;
  assign cf  = cm_valid && cm_ready;
  assign rec = cf && cm_mispredict;

  // occupancy seen from the handshakes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (rec) begin
      occ <= '0;
    end else begin
      unique case ({pf, cf})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R6
  cm_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_ready == (occ != '0));

  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(CKPT_DEPTH)) |-> !pred_ready);

  // R11
  recover_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec |-> !pred_ready);

  // R5
  spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf |=> (ghist[0] == $past(pred_taken)) &&
           (ghist[HIST_W-1:1] == $past(ghist[HIST_W-2:0])));

  // R8
  recover_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> !cm_ready);

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf && !rec) |=> $stable(ghist));

endmodule

bind gshare_predictor gshare_predictor_chk #(
  .HIST_W     (HIST_W),
  .CKPT_DEPTH (CKPT_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pred_valid    (pred_valid),
  .pred_ready    (pred_ready),
  .pred_taken    (pred_taken),
  .cm_valid      (cm_valid),
  .cm_ready      (cm_ready),
  .cm_mispredict (cm_mispredict),
  .ghist         (ghist)
);

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid = 1'b0, pred_ready, pred_taken;
  logic [31:0] pred_pc = '0, cm_pc = '0;
  logic        cm_valid = 1'b0, cm_ready, cm_taken = 1'b0, cm_mispredict = 1'b0;
  logic [7:0]  ghist;

  int checks = 0;
  int fails  = 0;

  logic [1:0]  m_pht [256];
  logic [7:0]  m_hist;
  logic [7:0]  m_q_hist [D];
  logic [31:0] m_q_pc [D];
  logic        m_q_pred [D];
  int          m_cnt;
  logic        last_pt;

  always #5 clk = ~clk;

  gshare_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_pc(pred_pc), .pred_taken(pred_taken),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_pc(cm_pc),
    .cm_taken(cm_taken), .cm_mispredict(cm_mispredict),
    .ghist(ghist)
  );

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) m_pht[i] = 2'b01;
    m_hist = '0;
    m_cnt  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_cycle(input bit pv, input logic [31:0] ppc, input bit cv,
                          input bit ct, input bit mp_force, input bit mp_val);
    bit mp, cfire, rec, pfire, exp_pr, exp_pt;
    logic [7:0] h0, ci;
    string tag;
    @(negedge clk);
    pred_valid = pv;
    pred_pc    = ppc;
    cm_valid   = cv;
    cm_taken   = ct;
    cm_pc      = (m_cnt > 0) ? m_q_pc[0] : (ppc ^ 32'h1C);
    mp = mp_force ? mp_val : ((m_cnt > 0) ? (ct != m_q_pred[0]) : 1'b0);
    cm_mispredict = mp;
    #1;
    cfire  = cv && (m_cnt > 0);
    rec    = cfire && mp;
    exp_pr = (m_cnt < D) && !rec;
    h0     = m_hist;
    exp_pt = m_pht[ppc[9:2] ^ h0][1];
    check((m_cnt > 0) ? "R6" : "R12", {31'd0, cm_ready}, {31'd0, m_cnt > 0});
    check(rec ? "R11" : "R10", {31'd0, pred_ready}, {31'd0, exp_pr});
    pfire = pv && exp_pr;
    if (pv) begin
      last_pt = pred_taken;
      if (exp_pr) check("R2", {31'd0, pred_taken}, {31'd0, exp_pt});
    end
    // R9: training uses the committed address and the oldest checkpoint
    if (cfire) begin
      ci = m_q_pc[0][9:2] ^ m_q_hist[0];
      m_pht[ci] = sat(m_pht[ci], ct);
    end
    if (rec) begin
      m_hist = {m_q_hist[0][6:0], ct};
      m_cnt  = 0;
    end else if (cfire) begin
      for (int i = 0; i < D - 1; i++) begin
        m_q_hist[i] = m_q_hist[i+1];
        m_q_pc[i]   = m_q_pc[i+1];
        m_q_pred[i] = m_q_pred[i+1];
      end
      m_cnt--;
    end
    if (pfire) begin
      m_q_hist[m_cnt] = h0;
      m_q_pc[m_cnt]   = ppc;
      m_q_pred[m_cnt] = exp_pt;
      m_cnt++;
      m_hist = {h0[6:0], exp_pt};
    end
    @(posedge clk);
    #1;
    tag = pfire ? "R5" : (rec ? "R8" : ((pv && !exp_pr) ? "R10" : "R7"));
    check(tag, {24'd0, ghist}, {24'd0, m_hist});
  endtask

  // predict at a fixed table index, then commit it with the given outcome
  task automatic train_step(input logic [7:0] tgt, input bit act, input bit exp_pred,
                            input string req);
    do_cycle(1'b1, {22'd0, tgt ^ m_hist, 2'b00}, 1'b0, 1'b0, 1'b0, 1'b0);
    check(req, {31'd0, last_pt}, {31'd0, exp_pred});
    do_cycle(1'b0, 32'd0, 1'b1, act, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1;
    // R1 reset state
    check("R1", {24'd0, ghist}, 32'd0);
    check("R1", {31'd0, pred_ready}, 32'd1);
    check("R1", {31'd0, cm_ready}, 32'd0);
    pred_pc = 32'h0000_0124;
    #1;
    check("R1", {31'd0, pred_taken}, 32'd0);
    pred_pc = 32'h0000_03FC;
    #1;
    check("R1", {31'd0, pred_taken}, 32'd0);

    // R3 / R4 one counter through both saturation ends
    train_step(8'h5A, 1'b1, 1'b0, "R4");
    train_step(8'h5A, 1'b1, 1'b1, "R4");
    train_step(8'h5A, 1'b1, 1'b1, "R3");
    train_step(8'h5A, 1'b0, 1'b1, "R3");
    train_step(8'h5A, 1'b0, 1'b1, "R4");
    train_step(8'h5A, 1'b0, 1'b0, "R4");
    train_step(8'h5A, 1'b0, 1'b0, "R3");
    train_step(8'h5A, 1'b1, 1'b0, "R3");
    train_step(8'h5A, 1'b1, 1'b0, "R3");
    train_step(8'h5A, 1'b1, 1'b1, "R4");

    // R12 commit into an empty queue
    do_cycle(1'b0, 32'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R12", {31'd0, cm_ready}, 32'd0);

    // R10 fill the queue, then present more
    for (int i = 0; i < D; i++) begin
      do_cycle(1'b1, 32'h40 + 32'(i * 4), 1'b0, 1'b0, 1'b0, 1'b0);
    end
    do_cycle(1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 1'b0);
    do_cycle(1'b1, 32'h204, 1'b1, m_q_pred[0], 1'b0, 1'b0);
    // R11 mispredicted commit together with a prediction
    do_cycle(1'b1, 32'h208, 1'b1, ~m_q_pred[0], 1'b0, 1'b0);
    // R7 correct commits drain
    do_cycle(1'b1, 32'h20C, 1'b0, 1'b0, 1'b0, 1'b0);
    do_cycle(1'b0, 32'd0, 1'b1, m_q_pred[0], 1'b0, 1'b0);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit pv, cv, ct, fm;
      logic [31:0] pc;
      pv = ($urandom % 4) != 0;
      cv = ($urandom % 3) == 0;
      pc = ($urandom % 64) << 2;
      if (($urandom % 2) == 1) pc = pc | 32'h300;
      ct = (m_cnt > 0) ? ((($urandom % 4) == 0) ? ~m_q_pred[0] : m_q_pred[0])
                       : 1'($urandom);
      fm = ($urandom % 16) == 0;
      do_cycle(pv, pc, cv, ct, fm, 1'($urandom));
    end

    pred_valid = 1'b0;
    cm_valid   = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule